// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests from 32 sources and dispatches them one at a time to a small processor core. A request pulse on a source line sets a pending flag for that source, and the flag is set whether or not the source is enabled. Each source has a two-bit priority made from one bit in a low enable register and one bit in a high enable register. A priority of zero disables the source. Among enabled pending sources, the controller picks the highest priority. When several sources share that priority, the lowest-numbered one wins. The controller drives the winner's index to the core as a vector with a request strobe, and it clears that pending flag as the request is issued.

A gate counter controls all dispatching: requests go out only while the counter reads zero. Software raises the counter by writing to an increment register and lowers it by writing to a decrement register. The counter starts at one, so interrupts are blocked after reset until software opens the gate. Software can read the pending flags to poll disabled sources. It clears flags by writing ones to them. A 16-bit register port holds the enable, pending and counter registers. Reads from this port are combinational and writes take effect at the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle high on `src_i[i]` sets pending flag i at the next edge, whatever the enable setting. The flags of sources 0..15 read at address 4 and those of sources 16..31 at address 5, with source i at bit i mod 16.
- R2: A write to address 4 or 5 clears every pending flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R3: If a source request and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R4: The priority of source i is {high bit, low bit}. The low bits sit at address 0 (sources 0..15) and address 1 (sources 16..31), and the high bits at addresses 2 and 3. The value 00 means disabled, and a disabled source is never dispatched while its flag stays set.
- R5: When the gate is open, the edge after an enabled flag becomes visible raises `irq_req_o` with `irq_vec_o` set to the source index, and the same edge clears that flag.
- R6: When several enabled flags are pending, the one with the highest priority (3 > 2 > 1) is dispatched first.
- R7: Among pending sources of equal highest priority, the lowest index is dispatched first.
- R8: `irq_req_o` and `irq_vec_o` hold until `irq_ack_i` is sampled high. The edge that takes the acknowledge drops the request, and no new request is issued on that edge.
- R9: The gate counter reads at address 6 and is 1 after reset. Any write to address 7 adds one and any write to address 8 subtracts one.
- R10: No request is issued while the counter is nonzero, and enabled flags stay pending until it returns to zero.
- R11: The counter saturates at 0 on decrement and at 15 on increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Request pulses, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 5 | Index of the source being requested |
| irq_ack_i | input | 1 | Core acknowledge of the current request |

## Verification
The bench fires batches of sources in one cycle with mixed priorities and ties. An arbiter that compares priorities the wrong way, or breaks ties toward the higher index, then sends vectors in an order the scoreboard rejects. A request and a write-one-to-clear hit the same flag in one cycle, so a design that lets the clear win loses the flag on readback. The bench drives the gate counter past both saturation limits, where a wrapping counter would read 15 or 0 instead of the limit. It leaves enabled flags pending while the counter is nonzero, which catches a gate that is ignored. It holds acknowledges back for several cycles, which exposes a request that drops early or a vector that changes while it is held.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    PRIO_OFF = 2'b00,
    PRIO_LO  = 2'b01,
    PRIO_MID = 2'b10,
    PRIO_HI  = 2'b11
  } prio_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] w1c_i,
  input  logic [N_SRC-1:0] disp_clr_i,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flags_q;

  // hardware set overrides both clear paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~w1c_i & ~disp_clr_i) | set_i;
  end

  assign flags_o = flags_q;

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  p_one_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_clr_i));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 32,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]      pend_i,
  input  logic [N_SRC-1:0][1:0] prio_i,
  output logic                  valid_o,
  output logic [IDX_W-1:0]      idx_o
);
  logic [1:0] best;

  // scan from the top so ties settle on the lowest index
  always_comb begin
    best    = 2'd0;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && prio_i[i] != 2'd0 && prio_i[i] >= best) begin
        best    = prio_i[i];
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      p_winner_enabled_r6: assert (pend_i[idx_o] && prio_i[idx_o] != 2'd0);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int          CNT_W   = 4,
  parameter int unsigned CNT_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             open_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(CNT_RST);
    else if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign open_o = (cnt_q == '0);

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && inc_i) |=> (cnt_q == CNT_MAX));

  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_i && !inc_i) |=> (cnt_q == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          N_SRC   = 32,
  parameter int          REG_W   = 16,
  parameter int          CNT_W   = 4,
  parameter int unsigned CNT_RST = 1,
  localparam int         N_SET   = N_SRC / REG_W,
  localparam int         IDX_W   = $clog2(N_SRC),
  localparam int         ADDR_W  = $clog2(3 * N_SET + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i
);
  import irq_pkg::*;

  localparam int A_FLAG = 2 * N_SET;
  localparam int A_CNT  = 3 * N_SET;
  localparam int A_INC  = A_CNT + 1;
  localparam int A_DEC  = A_CNT + 2;

  logic [N_SET-1:0][REG_W-1:0] en_lo_q, en_hi_q;
  logic [N_SRC-1:0]            w1c, disp_clr, flags;
  logic [N_SRC-1:0][1:0]       prio;
  logic                        pick_valid, gate_open, issue;
  logic [IDX_W-1:0]            pick_idx;
  logic [CNT_W-1:0]            cnt;
  logic                        req_q;
  logic [IDX_W-1:0]            vec_q;

  for (genvar k = 0; k < N_SET; k++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_lo_q[k] <= '0;
        en_hi_q[k] <= '0;
      end else if (reg_we_i) begin
        if (reg_addr_i == ADDR_W'(k))         en_lo_q[k] <= reg_wdata_i;
        if (reg_addr_i == ADDR_W'(N_SET + k)) en_hi_q[k] <= reg_wdata_i;
      end
    end

    assign w1c[k*REG_W +: REG_W] =
      (reg_we_i && reg_addr_i == ADDR_W'(A_FLAG + k)) ? reg_wdata_i : '0;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      assign prio[k*REG_W + b] = {en_hi_q[k][b], en_lo_q[k][b]};
    end
  end

  irq_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (src_i),
    .w1c_i     (w1c),
    .disp_clr_i(disp_clr),
    .flags_o   (flags)
  );

  irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .pend_i (flags),
    .prio_i (prio),
    .valid_o(pick_valid),
    .idx_o  (pick_idx)
  );

  irq_gate #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (reg_we_i && reg_addr_i == ADDR_W'(A_INC)),
    .dec_i (reg_we_i && reg_addr_i == ADDR_W'(A_DEC)),
    .cnt_o (cnt),
    .open_o(gate_open)
  );

  assign issue = !req_q && gate_open && pick_valid;

  always_comb begin
    disp_clr = '0;
    if (issue) disp_clr[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (req_q) begin
      if (irq_ack_i) req_q <= 1'b0;
    end else if (issue) begin
      req_q <= 1'b1;
      vec_q <= pick_idx;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < N_SET; k++) begin
      if (reg_addr_i == ADDR_W'(k))          reg_rdata_o = en_lo_q[k];
      if (reg_addr_i == ADDR_W'(N_SET + k))  reg_rdata_o = en_hi_q[k];
      if (reg_addr_i == ADDR_W'(A_FLAG + k)) reg_rdata_o = flags[k*REG_W +: REG_W];
    end
    if (reg_addr_i == ADDR_W'(A_CNT)) reg_rdata_o = REG_W'(cnt);
  end

  p_gate_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> ($past(cnt) == '0));

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(irq_vec_o)));

  p_ack_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !irq_req_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_req_o;
  logic [4:0]  irq_vec_o;
  logic        irq_ack_i = 1'b0;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  bit busy = 1'b0;

  always #5 clk_i = ~clk_i;

  prio_irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
    .irq_ack_i(irq_ack_i)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = int'(reg_rdata_o);
  endtask

  task automatic pulse(logic [31:0] s);
    @(negedge clk_i);
    src_i = s;
    @(negedge clk_i);
    src_i = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !busy) break;
    end
    repeat (6) @(negedge clk_i);
    check("R5 queue drained", exp_q.size(), 0);
  endtask

  // monitor: pop expected vector on each new request, hold ack back
  initial begin
    forever begin
      @(negedge clk_i);
      if (irq_req_o) begin
        int v;
        busy = 1'b1;
        v = int'(irq_vec_o);
        if (exp_q.size() == 0) begin
          check("R5 unexpected request", v, 99);
        end else begin
          check("R6/R7 dispatch order", v, exp_q.pop_front());
        end
        repeat (2) begin
          @(negedge clk_i);
          check("R8 request held", int'(irq_req_o), 1);
          check("R8 vector stable", int'(irq_vec_o), v);
        end
        irq_ack_i = 1'b1;
        @(negedge clk_i);
        irq_ack_i = 1'b0;
        check("R8 request dropped on ack", int'(irq_req_o), 0);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset state
    rd(4'd6, v); check("R9 counter reset", v, 1);
    check("R5 no request at reset", int'(irq_req_o), 0);
    rd(4'd4, v); check("R1 flags reset", v, 0);

    // open gate
    wr(4'd8, 16'h0);
    rd(4'd6, v); check("R9 decrement", v, 0);

    // R1/R4: disabled sources latch but never dispatch
    pulse(32'h0010_0008);
    repeat (5) @(negedge clk_i);
    check("R4 disabled no request", int'(irq_req_o), 0);
    rd(4'd4, v); check("R1 flag low set", v, 16'h0008);
    rd(4'd5, v); check("R1 flag high set", v, 16'h0010);

    // R2 write one to clear
    wr(4'd4, 16'h0008);
    rd(4'd4, v); check("R2 cleared by one", v, 0);
    wr(4'd5, 16'h0000);
    rd(4'd5, v); check("R2 zero leaves flag", v, 16'h0010);
    wr(4'd5, 16'h0010);
    rd(4'd5, v); check("R2 cleared high", v, 0);

    // R3 set beats clear in same cycle
    wr(4'd4, 16'h0020);
    @(negedge clk_i);
    src_i = 32'h0000_0020; reg_addr_i = 4'd4; reg_wdata_i = 16'h0020; reg_we_i = 1'b1;
    @(negedge clk_i);
    src_i = '0; reg_we_i = 1'b0;
    rd(4'd4, v); check("R3 set wins", v, 16'h0020);
    wr(4'd4, 16'h0020);

    // R11 saturation
    wr(4'd8, 16'h0);
    rd(4'd6, v); check("R11 floor at zero", v, 0);
    for (int i = 0; i < 20; i++) wr(4'd7, 16'h0);
    rd(4'd6, v); check("R11 ceiling at 15", v, 15);
    for (int i = 0; i < 14; i++) wr(4'd8, 16'h0);
    rd(4'd6, v); check("R9 back to one", v, 1);

    // R10 gate closed holds enabled pending flag
    wr(4'd0, 16'h0080);
    pulse(32'h0000_0080);
    repeat (6) @(negedge clk_i);
    check("R10 no request while gated", int'(irq_req_o), 0);
    rd(4'd4, v); check("R10 flag still pending", v, 16'h0080);
    exp_q.push_back(7);
    wr(4'd8, 16'h0);
    drain();
    rd(4'd4, v); check("R5 flag cleared on dispatch", v, 0);

    // R6 priorities released at once when gate reopens
    wr(4'd7, 16'h0);
    wr(4'd0, 16'h0284);          // src2 p1, src7 p1, src9 low bit
    wr(4'd2, 16'h0200);          // src9 high bit -> p3
    wr(4'd1, 16'h0004);          // src18 low bit
    wr(4'd3, 16'h0204);          // src18 high -> p3, src25 p2
    pulse(32'h0204_0204);
    exp_q.push_back(9);
    exp_q.push_back(18);
    exp_q.push_back(25);
    exp_q.push_back(2);
    wr(4'd8, 16'h0);
    drain();
    rd(4'd4, v); check("R6 low flags empty", v, 0);
    rd(4'd5, v); check("R6 high flags empty", v, 0);

    // R7 equal priority tie, gate open
    wr(4'd2, 16'h1210);          // src4, src12 p2
    exp_q.push_back(4);
    exp_q.push_back(12);
    pulse(32'h0000_1010);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule